// File: doc/BRIEF.md
# Key-Protected Pad Configuration Register Bank

This block holds the per-pin configuration that pad logic needs for a small I/O port: which pins are handed to an alternate function, three drive-strength selects, open-drain, pull-up and pull-down enables, slew control, and digital and analog enables. Each setting is a vector with one bit per pin. All of them are reached through a simple memory-mapped register interface: a write strobe with address and data, and a read data bus that is decoded combinationally from the address.

Most registers are ordinary read/write storage. The alternate-function vector is guarded by a commit mask. A write to it changes only the pins whose commit bit is set. The commit mask is guarded in turn by a lock. The mask can be rewritten only after the exact 32-bit key 0x0ACCE551 has been written to the lock register. Any other value written there restores the lock. Software therefore needs a key write, a commit write and only then an alternate-function write before it can move a protected pin to another function.

Top module: `pad_cfg_top`

## Requirements
- R1: While reset is asserted, on the next clock the bank is locked, the commit mask is all ones, and every other configuration register is 0.
- R2: A write of exactly 0x0ACCE551 to the lock register (offset 0x520) unlocks the bank. The lock register then reads 0.
- R3: A write of any other value to the lock register locks the bank. The lock register then reads 1.
- R4: A write to the commit register (offset 0x524) stores the low PINS bits of the data only while the bank is unlocked. While the bank is locked, the write has no effect.
- R5: A write to the alternate-function register (offset 0x420) updates only the bits whose commit bit is 1. Every other bit keeps its value.
- R6: The plain registers store the low PINS bits of each write, read them back, and drive them on their output port. Their offsets are: analog enable 0x528, pull-down 0x514, 8 mA drive 0x508, digital enable 0x51C, open drain 0x50C, 2 mA drive 0x500, slew 0x518, pull-up 0x510, 4 mA drive 0x504.
- R7: Read data bits above PINS-1 are always 0. A read of an unmapped offset returns 0.
- R8: A write to an unmapped offset changes no register, and a write to one register changes no other register.
- R9: The lock state has no effect on writes to or reads of the plain registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, decoded combinationally from addr |
| alt_func | output | PINS | Alternate-function select per pin |
| drive_2ma | output | PINS | 2 mA drive select |
| drive_4ma | output | PINS | 4 mA drive select |
| drive_8ma | output | PINS | 8 mA drive select |
| open_drain | output | PINS | Open-drain enable |
| pull_up | output | PINS | Pull-up enable |
| pull_down | output | PINS | Pull-down enable |
| slew_ctl | output | PINS | Slew-rate control |
| dig_en | output | PINS | Digital enable |
| ana_en | output | PINS | Analog mode enable |

## Verification
The bench builds the block with the default PINS = 8, so each register is one byte. With one-byte registers, random write data covers every commit-mask pattern, and the bits above the register width are often set and must be dropped. Random writes mix the exact key with near-miss values, so the bank moves between locked and unlocked many times, and commit writes arrive in both states. The alternate-function writes then see many different masks. Directed cases cover reset, a key off by one bit, an empty and a partial commit mask, and writes to unmapped offsets.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int PINS_DEFAULT = 8;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;

    localparam logic [ADDR_W-1:0] OFS_ALTFN  = 12'h420;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h520;
    localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;
    localparam logic [ADDR_W-1:0] OFS_PLAIN_BASE = 12'h500;
    localparam logic [ADDR_W-1:0] OFS_ANALOG = 12'h528;

    typedef enum logic [3:0] {
        PR_DRV2   = 4'd0,
        PR_DRV4   = 4'd1,
        PR_DRV8   = 4'd2,
        PR_ODRAIN = 4'd3,
        PR_PULLUP = 4'd4,
        PR_PULLDN = 4'd5,
        PR_SLEW   = 4'd6,
        PR_DIGEN  = 4'd7,
        PR_ANAEN  = 4'd8
    } plain_idx_e;

    localparam int NUM_PLAIN = 9;

    typedef struct packed {
        logic       hit;
        logic [3:0] idx;
    } plain_hit_t;

    // Offset of a plain register: a contiguous run of words, then the analog enable.
    function automatic logic [ADDR_W-1:0] plain_offset(input int idx);
        if (idx == NUM_PLAIN - 1)
            return OFS_ANALOG;
        return OFS_PLAIN_BASE + ADDR_W'(idx * 4);
    endfunction

    function automatic plain_hit_t decode_plain(input logic [ADDR_W-1:0] a);
        plain_hit_t r;
        r = '0;
        for (int i = 0; i < NUM_PLAIN; i++) begin
            if (a == plain_offset(i)) begin
                r.hit = 1'b1;
                r.idx = 4'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pad_cfg_lock.sv
module pad_cfg_lock
    import pad_cfg_pkg::*;
#(
    parameter int PINS = PINS_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_wr,
    input  logic              commit_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked,
    output logic [PINS-1:0]   commit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b1;
            commit <= '1;
        end else begin
            if (lock_wr)
                locked <= (wdata != UNLOCK_KEY);
            if (commit_wr && !locked)
                commit <= wdata[PINS-1:0];
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (locked && (commit == '1))); // R1

    AST_UNLOCK_ON_KEY: assert property (@(posedge clk) disable iff (rst)
        (lock_wr && (wdata == UNLOCK_KEY)) |=> !locked); // R2

    AST_RELOCK_ON_OTHER: assert property (@(posedge clk) disable iff (rst)
        (lock_wr && (wdata != UNLOCK_KEY)) |=> locked); // R3

    AST_COMMIT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        locked |=> (commit == $past(commit))); // R4

endmodule

// File: rtl/pad_cfg_altfn.sv
module pad_cfg_altfn
    import pad_cfg_pkg::*;
#(
    parameter int PINS = PINS_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] commit,
    output logic [PINS-1:0] alt_q
);

    always_ff @(posedge clk) begin
        if (rst)
            alt_q <= '0;
        else if (wr_en)
            alt_q <= (alt_q & ~commit) | (wdata & commit);
    end

    AST_ALTFN_GATED: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((alt_q ^ $past(alt_q)) & ~$past(commit)) == '0)); // R5

    AST_ALTFN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(alt_q)); // R8

endmodule

// File: rtl/pad_cfg_plain_bank.sv
module pad_cfg_plain_bank
    import pad_cfg_pkg::*;
#(
    parameter int PINS = PINS_DEFAULT,
    parameter int NREG = NUM_PLAIN
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [3:0]                 wr_idx,
    input  logic [PINS-1:0]            wdata,
    output logic [NREG-1:0][PINS-1:0]  regs_q
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else if (wr_en && (wr_idx == 4'(g)))
                regs_q[g] <= wdata;
        end

        AST_PLAIN_LOAD: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_idx == 4'(g))) |=> (regs_q[g] == $past(wdata))); // R6

        AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && (wr_idx == 4'(g))) |=> $stable(regs_q[g])); // R8
    end

endmodule

// File: rtl/pad_cfg_top.sv
module pad_cfg_top
    import pad_cfg_pkg::*;
#(
    parameter int PINS = PINS_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [PINS-1:0]   alt_func,
    output logic [PINS-1:0]   drive_2ma,
    output logic [PINS-1:0]   drive_4ma,
    output logic [PINS-1:0]   drive_8ma,
    output logic [PINS-1:0]   open_drain,
    output logic [PINS-1:0]   pull_up,
    output logic [PINS-1:0]   pull_down,
    output logic [PINS-1:0]   slew_ctl,
    output logic [PINS-1:0]   dig_en,
    output logic [PINS-1:0]   ana_en
);

    plain_hit_t                      hit;
    logic                            locked;
    logic [PINS-1:0]                 commit;
    logic [PINS-1:0]                 alt_q;
    logic [NUM_PLAIN-1:0][PINS-1:0]  plain_q;

    assign hit = decode_plain(addr);

    pad_cfg_lock #(.PINS(PINS)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .lock_wr   (wr_en && (addr == OFS_LOCK)),
        .commit_wr (wr_en && (addr == OFS_COMMIT)),
        .wdata     (wdata),
        .locked    (locked),
        .commit    (commit)
    );

    pad_cfg_altfn #(.PINS(PINS)) u_altfn (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en && (addr == OFS_ALTFN)),
        .wdata  (wdata[PINS-1:0]),
        .commit (commit),
        .alt_q  (alt_q)
    );

    pad_cfg_plain_bank #(.PINS(PINS), .NREG(NUM_PLAIN)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en && hit.hit),
        .wr_idx (hit.idx),
        .wdata  (wdata[PINS-1:0]),
        .regs_q (plain_q)
    );

    always_comb begin
        rdata = '0;
        if (hit.hit)
            rdata = DATA_W'(plain_q[hit.idx]);
        else if (addr == OFS_ALTFN)
            rdata = DATA_W'(alt_q);
        else if (addr == OFS_LOCK)
            rdata = DATA_W'(locked);
        else if (addr == OFS_COMMIT)
            rdata = DATA_W'(commit);
    end

    assign alt_func   = alt_q;
    assign drive_2ma  = plain_q[PR_DRV2];
    assign drive_4ma  = plain_q[PR_DRV4];
    assign drive_8ma  = plain_q[PR_DRV8];
    assign open_drain = plain_q[PR_ODRAIN];
    assign pull_up    = plain_q[PR_PULLUP];
    assign pull_down  = plain_q[PR_PULLDN];
    assign slew_ctl   = plain_q[PR_SLEW];
    assign dig_en     = plain_q[PR_DIGEN];
    assign ana_en     = plain_q[PR_ANAEN];

    AST_RDATA_NARROW: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:PINS] == '0); // R7

    AST_OUT_MATCHES_READ: assert property (@(posedge clk) disable iff (rst)
        (addr == OFS_ALTFN) |-> (rdata[PINS-1:0] == alt_func)); // R6

endmodule

// File: tb/tb_pad_cfg_top.sv
`timescale 1ns/1ps
module tb_pad_cfg_top;

    localparam int PINS = 8;
    localparam logic [31:0] KEY = 32'h0ACC_E551;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [PINS-1:0] alt_func, drive_2ma, drive_4ma, drive_8ma, open_drain;
    logic [PINS-1:0] pull_up, pull_down, slew_ctl, dig_en, ana_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pad_cfg_top #(.PINS(PINS)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .alt_func(alt_func), .drive_2ma(drive_2ma),
        .drive_4ma(drive_4ma), .drive_8ma(drive_8ma), .open_drain(open_drain),
        .pull_up(pull_up), .pull_down(pull_down), .slew_ctl(slew_ctl),
        .dig_en(dig_en), .ana_en(ana_en)
    );

    // Bench model of the register state
    logic            m_lock;
    logic [PINS-1:0] m_cmt;
    logic [PINS-1:0] m_af;
    logic [PINS-1:0] m_plain [9];

    function automatic logic [11:0] ofs(input int i);
        return (i == 8) ? 12'h528 : 12'(12'h500 + i * 4);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        for (int i = 0; i < 9; i++)
            if (a == ofs(i)) return 32'(m_plain[i]);
        if (a == 12'h420) return 32'(m_af);
        if (a == 12'h520) return 32'(m_lock);
        if (a == 12'h524) return 32'(m_cmt);
        return 32'h0;
    endfunction

    function automatic logic [PINS-1:0] dut_out(input int i);
        case (i)
            0: return drive_2ma;
            1: return drive_4ma;
            2: return drive_8ma;
            3: return open_drain;
            4: return pull_up;
            5: return pull_down;
            6: return slew_ctl;
            7: return dig_en;
            default: return ana_en;
        endcase
    endfunction

    task automatic model_reset();
        m_lock = 1'b1;
        m_cmt = '1;
        m_af = '0;
        for (int i = 0; i < 9; i++) m_plain[i] = '0;
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        for (int i = 0; i < 9; i++)
            if (a == ofs(i)) m_plain[i] = d[PINS-1:0];
        if (a == 12'h420) m_af = (m_af & ~m_cmt) | (d[PINS-1:0] & m_cmt);
        if (a == 12'h524 && !m_lock) m_cmt = d[PINS-1:0];
        if (a == 12'h520) m_lock = (d != KEY);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp_rd(a));
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 9; i++) begin
            rd_chk(req, ofs(i));
            chk({req, " port"}, 32'(dut_out(i)), 32'(m_plain[i]));
        end
        rd_chk(req, 12'h420);
        chk({req, " alt port"}, 32'(alt_func), 32'(m_af));
        rd_chk(req, 12'h520);
        rd_chk(req, 12'h524);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_all("R1");

        // R4: commit write while locked is ignored
        wr(12'h524, 32'h0000_0003);
        rd_chk("R4 locked commit", 12'h524);
        // R2/R3: key with one bit flipped keeps the bank locked
        wr(12'h520, KEY ^ 32'h1);
        rd_chk("R3 near-miss key", 12'h520);
        // R2: exact key unlocks
        wr(12'h520, KEY);
        rd_chk("R2 unlock", 12'h520);
        // R4: commit accepted while unlocked, upper bits dropped
        wr(12'h524, 32'hFFFF_FF0F);
        rd_chk("R4 unlocked commit", 12'h524);
        // R5: partial mask gates the alt-function write
        wr(12'h420, 32'h0000_00FF);
        rd_chk("R5 partial mask", 12'h420);
        chk("R5 alt port", 32'(alt_func), 32'h0F);
        // R5: empty mask freezes alt function
        wr(12'h524, 32'h0);
        wr(12'h420, 32'h0000_0000);
        rd_chk("R5 empty mask", 12'h420);
        // R3: relock, then commit write ignored
        wr(12'h520, 32'h0);
        rd_chk("R3 relock", 12'h520);
        wr(12'h524, 32'hFF);
        rd_chk("R4 ignored after relock", 12'h524);
        // R9, R6, R7: plain write while locked, upper bits dropped
        wr(12'h51C, 32'hFFFF_FFFF);
        rd_chk("R9 plain while locked", 12'h51C);
        chk("R7 upper bits", rdata & 32'hFFFF_FF00, 32'h0);
        // R8, R7: unmapped write and read
        wr(12'h440, 32'hFFFF_FFFF);
        rd_chk("R7 unmapped read", 12'h440);
        check_all("R8");

        // Constrained random
        for (int it = 0; it < 400; it++) begin
            int sel;
            logic [11:0] a;
            logic [31:0] d;
            sel = int'($urandom_range(0, 13));
            d = $urandom();
            if (sel <= 8) a = ofs(sel);
            else if (sel == 9) a = 12'h420;
            else if (sel == 10) a = 12'h524;
            else if (sel == 11) begin a = 12'h520; d = KEY; end
            else if (sel == 12) begin
                a = 12'h520;
                if ($urandom_range(0, 1) == 1) d = KEY ^ (32'h1 << $urandom_range(0, 31));
            end else a = 12'(12'h600 + 4 * $urandom_range(0, 63));
            wr(a, d);
            rd_chk("R6 random readback", a);
            if (sel == 9) chk("R5 random alt port", 32'(alt_func), 32'(m_af));
            if (sel == 10) rd_chk("R4 random commit", 12'h524);
            if (sel >= 11 && sel <= 12) rd_chk("R2 random lock", 12'h520);
            if (it % 40 == 0) check_all("R9 sweep");
        end
        check_all("R8 final");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule